// File: doc/BRIEF.md
# Checked Privileged Control Register Bank

This block keeps the privileged control state of a small processor core: a mode word, a captured fault address, a translation base register, a feature word, a 4-bit task-priority level and an extended state-enable mask. Software reaches each register through one index port that carries read and write strobes. Every write is screened against the rules of the register it targets before anything is stored. A write that breaks a rule is dropped and raises a general-protection pulse. An access to an index that has no register behind it raises an undefined-opcode pulse and changes nothing.

A fault-event input lets the memory pipeline record a faulting linear address with no software involvement. Decoded control levels are driven straight to the core from the stored state. These are protected mode, paging, large pages, extended physical addressing, the context identifier, the directory base and the priority level. The context-identifier field of the base register is only presented while the matching feature bit is on.

Top module: `scr_file`

## Requirements
- R1: Out of reset, registers 0, 2, 3, 4 and 8 read zero, and the extended mask (index 9) reads 1.
- R2: A read or write at index 1 or 5, or at any index other than 0, 2, 3, 4, 8 and 9, pulses ud_exc in the next cycle, returns zero read data and changes no register.
- R3: A read at index 0, 2, 3, 4, 8 or 9 returns that register, zero-extended, on rdata in the cycle after the strobe. A read that comes with a write in the same cycle returns the value from before the write. When no read was made, rdata is zero.
- R4: In register 0, bit 0 drives prot_en and bit 31 drives paging_en. A write with bit 31 set and bit 0 clear pulses gp_exc and is discarded.
- R5: A pulse on pf_valid loads register 2 with pf_addr. It wins over a software write to register 2 in the same cycle. A software write to register 2 on its own stores the data.
- R6: dir_base shows register 3 bits 63:12. ctx_id shows register 3 bits 11:0 while register 4 bit 17 is set, and zero otherwise.
- R7: large_pages follows register 4 bit 4, and phys_ext follows register 4 bit 5.
- R8: Register 8 holds only 4 bits, driven on prio_level. A write with any bit above bit 3 set pulses gp_exc and leaves the register unchanged.
- R9: A write to the extended mask (index 9) pulses gp_exc and is discarded when it has bit 0 clear, or bit 10 set, or any bit from 14 upward set. Other values are stored.
- R10: ud_exc and gp_exc are one-cycle pulses. They appear only in the cycle after an access and are never high together. A legal write is visible to a read made in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| idx | input | 4 | Register index |
| wdata | input | 64 | Write data |
| pf_valid | input | 1 | Fault event strobe |
| pf_addr | input | 64 | Faulting linear address |
| rdata | output | 64 | Read data, one cycle after rd_en |
| ud_exc | output | 1 | Undefined-opcode pulse |
| gp_exc | output | 1 | General-protection pulse |
| prot_en | output | 1 | Protected mode active |
| paging_en | output | 1 | Paging active |
| large_pages | output | 1 | 4 MiB page size selected |
| phys_ext | output | 1 | 36-bit physical addressing |
| ctx_id | output | 12 | Context identifier, gated by feature bit |
| dir_base | output | 52 | Page-directory base |
| prio_level | output | 4 | Task-priority level |

## Verification
The bench sets paging without protection, priority values one bit above the field, and masks that break each of the three mask rules one at a time. After each faulting write it reads back the register, so a design that stored the value and still raised the fault would show the wrong data. A fault event and a software write to register 2 arrive in the same cycle, which catches a reversed priority. A combined read and write checks that the read returns the old value, not the new one. The context identifier is checked with the gating bit both off and on, to expose a design that always passes the low base bits through. Reserved and unmapped indices are hit with writes and then followed by reads of live state, which exposes any decode that lets the write through.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [2:0] {
        SEL_MODE,
        SEL_FAULT,
        SEL_BASE,
        SEL_FEAT,
        SEL_PRIO,
        SEL_XMASK,
        SEL_NONE
    } sel_e;

    localparam int IDX_MODE  = 0;
    localparam int IDX_FAULT = 2;
    localparam int IDX_BASE  = 3;
    localparam int IDX_FEAT  = 4;
    localparam int IDX_PRIO  = 8;
    localparam int IDX_XMASK = 9;
endpackage

// File: rtl/scr_index_decode.sv
module scr_index_decode
    import scr_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic [IDXW-1:0] idx,
    output sel_e            sel
);
    always_comb begin
        sel = SEL_NONE;
        case (idx)
            IDXW'(IDX_MODE):  sel = SEL_MODE;
            IDXW'(IDX_FAULT): sel = SEL_FAULT;
            IDXW'(IDX_BASE):  sel = SEL_BASE;
            IDXW'(IDX_FEAT):  sel = SEL_FEAT;
            IDXW'(IDX_PRIO):  sel = SEL_PRIO;
            IDXW'(IDX_XMASK): sel = SEL_XMASK;
            default:          sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/scr_write_check.sv
module scr_write_check
    import scr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int PRIO_W      = 4,
    parameter int PE_BIT      = 0,
    parameter int PG_BIT      = 31,
    parameter int XM_BASE_BIT = 0,
    parameter int XM_HOLE_BIT = 10,
    parameter int XM_TOP_BIT  = 14
) (
    input  sel_e            sel,
    input  logic [XLEN-1:0] wdata,
    output logic            legal
);
    localparam logic [XLEN-1:0] ONE       = XLEN'(1);
    localparam logic [XLEN-1:0] PE_M      = ONE << PE_BIT;
    localparam logic [XLEN-1:0] PG_M      = ONE << PG_BIT;
    localparam logic [XLEN-1:0] PRIO_KEEP = (ONE << PRIO_W) - ONE;
    localparam logic [XLEN-1:0] XM_BASE_M = ONE << XM_BASE_BIT;
    localparam logic [XLEN-1:0] XM_RSVD_M = ~((ONE << XM_TOP_BIT) - ONE) | (ONE << XM_HOLE_BIT);

    always_comb begin
        legal = 1'b1;
        case (sel)
            SEL_MODE:  legal = !(((wdata & PG_M) != '0) && ((wdata & PE_M) == '0));
            SEL_PRIO:  legal = ((wdata & ~PRIO_KEEP) == '0);
            SEL_XMASK: legal = ((wdata & XM_BASE_M) != '0) && ((wdata & XM_RSVD_M) == '0);
            default:   legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/scr_view.sv
module scr_view #(
    parameter int XLEN     = 64,
    parameter int CTXW     = 12,
    parameter int PE_BIT   = 0,
    parameter int PG_BIT   = 31,
    parameter int PSE_BIT  = 4,
    parameter int PAE_BIT  = 5,
    parameter int CTXE_BIT = 17
) (
    input  logic [XLEN-1:0]      mode,
    input  logic [XLEN-1:0]      feat,
    input  logic [XLEN-1:0]      base,
    output logic                 prot_en,
    output logic                 paging_en,
    output logic                 large_pages,
    output logic                 phys_ext,
    output logic [CTXW-1:0]      ctx_id,
    output logic [XLEN-CTXW-1:0] dir_base
);
    localparam logic [XLEN-1:0] ONE    = XLEN'(1);
    localparam logic [XLEN-1:0] PE_M   = ONE << PE_BIT;
    localparam logic [XLEN-1:0] PG_M   = ONE << PG_BIT;
    localparam logic [XLEN-1:0] PSE_M  = ONE << PSE_BIT;
    localparam logic [XLEN-1:0] PAE_M  = ONE << PAE_BIT;
    localparam logic [XLEN-1:0] CTXE_M = ONE << CTXE_BIT;

    always_comb begin
        prot_en     = (mode & PE_M) != '0;
        paging_en   = (mode & PG_M) != '0;
        large_pages = (feat & PSE_M) != '0;
        phys_ext    = (feat & PAE_M) != '0;
        ctx_id      = ((feat & CTXE_M) != '0) ? base[CTXW-1:0] : '0;
        dir_base    = base[XLEN-1:CTXW];
    end
endmodule

// File: rtl/scr_file.sv
module scr_file
    import scr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int IDXW     = 4,
    parameter int PRIO_W   = 4,
    parameter int CTXW     = 12,
    parameter int PE_BIT   = 0,
    parameter int PG_BIT   = 31,
    parameter int PSE_BIT  = 4,
    parameter int PAE_BIT  = 5,
    parameter int CTXE_BIT = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      idx,
    input  logic [XLEN-1:0]      wdata,
    input  logic                 pf_valid,
    input  logic [XLEN-1:0]      pf_addr,
    output logic [XLEN-1:0]      rdata,
    output logic                 ud_exc,
    output logic                 gp_exc,
    output logic                 prot_en,
    output logic                 paging_en,
    output logic                 large_pages,
    output logic                 phys_ext,
    output logic [CTXW-1:0]      ctx_id,
    output logic [XLEN-CTXW-1:0] dir_base,
    output logic [PRIO_W-1:0]    prio_level
);
    localparam logic [XLEN-1:0] XMASK_RST = XLEN'(1);

    typedef struct packed {
        logic [XLEN-1:0]   mode;
        logic [XLEN-1:0]   fault;
        logic [XLEN-1:0]   base;
        logic [XLEN-1:0]   feat;
        logic [PRIO_W-1:0] prio;
        logic [XLEN-1:0]   xmask;
        logic [XLEN-1:0]   rdata;
        logic              ud;
        logic              gp;
    } state_t;

    state_t st_d, st_q;
    sel_e   sel;
    logic   wr_legal;
    logic   access;

    scr_index_decode #(.IDXW(IDXW)) u_dec (
        .idx (idx),
        .sel (sel)
    );

    scr_write_check #(
        .XLEN   (XLEN),
        .PRIO_W (PRIO_W),
        .PE_BIT (PE_BIT),
        .PG_BIT (PG_BIT)
    ) u_chk (
        .sel   (sel),
        .wdata (wdata),
        .legal (wr_legal)
    );

    always_comb begin
        access   = rd_en | wr_en;
        st_d     = st_q;
        st_d.ud  = 1'b0;
        st_d.gp  = 1'b0;
        st_d.rdata = '0;

        if (access && (sel == SEL_NONE)) begin
            st_d.ud = 1'b1;
        end else begin
            if (rd_en) begin
                case (sel)
                    SEL_MODE:  st_d.rdata = st_q.mode;
                    SEL_FAULT: st_d.rdata = st_q.fault;
                    SEL_BASE:  st_d.rdata = st_q.base;
                    SEL_FEAT:  st_d.rdata = st_q.feat;
                    SEL_PRIO:  st_d.rdata = {{(XLEN-PRIO_W){1'b0}}, st_q.prio};
                    SEL_XMASK: st_d.rdata = st_q.xmask;
                    default:   st_d.rdata = '0;
                endcase
            end
            if (wr_en) begin
                if (!wr_legal) begin
                    st_d.gp = 1'b1;
                end else begin
                    case (sel)
                        SEL_MODE:  st_d.mode  = wdata;
                        SEL_FAULT: st_d.fault = wdata;
                        SEL_BASE:  st_d.base  = wdata;
                        SEL_FEAT:  st_d.feat  = wdata;
                        SEL_PRIO:  st_d.prio  = wdata[PRIO_W-1:0];
                        SEL_XMASK: st_d.xmask = wdata;
                        default:   ;
                    endcase
                end
            end
        end

        // hardware capture of the faulting address takes precedence
        if (pf_valid) begin
            st_d.fault = pf_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.xmask <= XMASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    scr_view #(
        .XLEN     (XLEN),
        .CTXW     (CTXW),
        .PE_BIT   (PE_BIT),
        .PG_BIT   (PG_BIT),
        .PSE_BIT  (PSE_BIT),
        .PAE_BIT  (PAE_BIT),
        .CTXE_BIT (CTXE_BIT)
    ) u_view (
        .mode        (st_q.mode),
        .feat        (st_q.feat),
        .base        (st_q.base),
        .prot_en     (prot_en),
        .paging_en   (paging_en),
        .large_pages (large_pages),
        .phys_ext    (phys_ext),
        .ctx_id      (ctx_id),
        .dir_base    (dir_base)
    );

    assign rdata      = st_q.rdata;
    assign ud_exc     = st_q.ud;
    assign gp_exc     = st_q.gp;
    assign prio_level = st_q.prio;
endmodule

// File: rtl/scr_file_sva.sv
module scr_file_sva #(
    parameter int IDXW   = 4,
    parameter int PRIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [IDXW-1:0]   idx,
    input logic              ud_exc,
    input logic              gp_exc,
    input logic              prot_en,
    input logic              paging_en,
    input logic [PRIO_W-1:0] prio_level
);
    a_r2_reserved_traps: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && (idx == IDXW'(1) || idx == IDXW'(5))) |=> ud_exc);

    a_r2_reserved_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        ud_exc |-> ($stable(prio_level) && $stable(paging_en) && $stable(prot_en)));

    a_r4_paging_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
        paging_en |-> prot_en);

    a_r8_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        gp_exc |-> ($stable(prio_level) && $stable(paging_en) && $stable(prot_en)));

    a_r10_exc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ud_exc && gp_exc));

    a_r10_exc_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (ud_exc || gp_exc) |-> $past(rd_en || wr_en));
endmodule

bind scr_file scr_file_sva #(.IDXW(IDXW), .PRIO_W(PRIO_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .idx        (idx),
    .ud_exc     (ud_exc),
    .gp_exc     (gp_exc),
    .prot_en    (prot_en),
    .paging_en  (paging_en),
    .prio_level (prio_level)
);

// File: tb/scr_file_bench.sv
module scr_file_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  idx = '0;
    logic [63:0] wdata = '0;
    logic        pf_valid = 1'b0;
    logic [63:0] pf_addr = '0;
    logic [63:0] rdata;
    logic        ud_exc, gp_exc, prot_en, paging_en, large_pages, phys_ext;
    logic [11:0] ctx_id;
    logic [51:0] dir_base;
    logic [3:0]  prio_level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] r_data;
    logic        r_ud, r_gp;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr_file u_scr_file (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .idx(idx),
        .wdata(wdata), .pf_valid(pf_valid), .pf_addr(pf_addr), .rdata(rdata),
        .ud_exc(ud_exc), .gp_exc(gp_exc), .prot_en(prot_en), .paging_en(paging_en),
        .large_pages(large_pages), .phys_ext(phys_ext), .ctx_id(ctx_id),
        .dir_base(dir_base), .prio_level(prio_level)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic rd, input logic wr, input logic [3:0] i,
                       input logic [63:0] w, input logic pf, input logic [63:0] pa);
        @(negedge clk);
        rd_en = rd; wr_en = wr; idx = i; wdata = w; pf_valid = pf; pf_addr = pa;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; pf_valid = 1'b0;
        r_data = rdata; r_ud = ud_exc; r_gp = gp_exc;
    endtask

    task automatic wr(input logic [3:0] i, input logic [63:0] w);
        acc(1'b0, 1'b1, i, w, 1'b0, '0);
    endtask

    task automatic rd(input logic [3:0] i);
        acc(1'b1, 1'b0, i, '0, 1'b0, '0);
    endtask

    task automatic t_reset;
        rd(4'd0); chk("R1 mode reset", r_data, 64'd0);
        rd(4'd2); chk("R1 fault reset", r_data, 64'd0);
        rd(4'd3); chk("R1 base reset", r_data, 64'd0);
        rd(4'd4); chk("R1 feat reset", r_data, 64'd0);
        rd(4'd8); chk("R1 prio reset", r_data, 64'd0);
        rd(4'd9); chk("R1 xmask reset", r_data, 64'd1);
        chk("R1 flags reset", {prot_en, paging_en, large_pages, phys_ext}, 64'd0);
        @(negedge clk);
        chk("R3 idle rdata zero", rdata, 64'd0);
    endtask

    task automatic t_reserved;
        wr(4'd8, 64'd3);
        wr(4'd1, 64'd7);
        chk("R2 idx1 write ud", r_ud, 64'd1);
        chk("R2 idx1 write no gp", r_gp, 64'd0);
        rd(4'd5);
        chk("R2 idx5 read ud", r_ud, 64'd1);
        chk("R2 idx5 read data zero", r_data, 64'd0);
        wr(4'd7, 64'd9);
        chk("R2 idx7 ud", r_ud, 64'd1);
        rd(4'd8);
        chk("R2 state unchanged", r_data, 64'd3);
        chk("R2 no ud on legal read", r_ud, 64'd0);
    endtask

    task automatic t_mode;
        wr(4'd0, 64'h8000_0000);
        chk("R4 paging without prot gp", r_gp, 64'd1);
        chk("R4 paging stays off", paging_en, 64'd0);
        @(negedge clk);
        chk("R10 gp single pulse", gp_exc, 64'd0);
        rd(4'd0); chk("R4 mode discarded", r_data, 64'd0);
        wr(4'd0, 64'h1);
        chk("R4 prot only legal", r_gp, 64'd0);
        chk("R4 prot_en on", prot_en, 64'd1);
        wr(4'd0, 64'h8000_0001);
        chk("R4 paging with prot legal", r_gp, 64'd0);
        chk("R4 paging_en on", paging_en, 64'd1);
        wr(4'd0, 64'h8000_0000);
        chk("R4 clearing prot with paging gp", r_gp, 64'd1);
        rd(4'd0); chk("R4 mode kept", r_data, 64'h8000_0001);
    endtask

    task automatic t_fault;
        acc(1'b0, 1'b0, 4'd0, '0, 1'b1, 64'hDEAD_BEEF_0000_1234);
        rd(4'd2); chk("R5 event load", r_data, 64'hDEAD_BEEF_0000_1234);
        acc(1'b0, 1'b1, 4'd2, 64'h1111, 1'b1, 64'h2222);
        chk("R5 no exc on collide", {r_ud, r_gp}, 64'd0);
        rd(4'd2); chk("R5 event wins", r_data, 64'h2222);
        wr(4'd2, 64'h3333);
        rd(4'd2); chk("R5 software write", r_data, 64'h3333);
    endtask

    task automatic t_base;
        wr(4'd3, 64'h0000_0001_2345_6ABC);
        chk("R6 dir_base", {12'd0, dir_base}, 64'h0000_0000_1234_56);
        chk("R6 ctx hidden", ctx_id, 64'd0);
        wr(4'd4, 64'h0002_0000);
        chk("R6 ctx shown", ctx_id, 64'hABC);
        chk("R7 flags off", {large_pages, phys_ext}, 64'd0);
        wr(4'd4, 64'h10);
        chk("R7 large_pages", {large_pages, phys_ext}, 64'd2);
        chk("R6 ctx hidden again", ctx_id, 64'd0);
        wr(4'd4, 64'h20);
        chk("R7 phys_ext", {large_pages, phys_ext}, 64'd1);
        rd(4'd3); chk("R3 base readback", r_data, 64'h0000_0001_2345_6ABC);
    endtask

    task automatic t_prio;
        wr(4'd8, 64'd9);
        chk("R8 legal write", r_gp, 64'd0);
        chk("R8 prio_level", prio_level, 64'd9);
        wr(4'd8, 64'h10);
        chk("R8 upper bit gp", r_gp, 64'd1);
        chk("R8 kept", prio_level, 64'd9);
        wr(4'd8, 64'h8000_0000_0000_0000);
        chk("R8 top bit gp", r_gp, 64'd1);
        wr(4'd8, 64'hF);
        rd(4'd8); chk("R8 max value", r_data, 64'hF);
    endtask

    task automatic t_xmask;
        wr(4'd9, 64'h206);
        chk("R9 bit0 clear gp", r_gp, 64'd1);
        wr(4'd9, 64'h401);
        chk("R9 bit10 gp", r_gp, 64'd1);
        wr(4'd9, 64'h4001);
        chk("R9 bit14 gp", r_gp, 64'd1);
        rd(4'd9); chk("R9 discarded", r_data, 64'd1);
        wr(4'd9, 64'h2207);
        chk("R9 legal no gp", r_gp, 64'd0);
        rd(4'd9); chk("R9 stored", r_data, 64'h2207);
    endtask

    task automatic t_both;
        wr(4'd8, 64'd4);
        acc(1'b1, 1'b1, 4'd8, 64'd6, 1'b0, '0);
        chk("R3 read returns old value", r_data, 64'd4);
        rd(4'd8); chk("R10 write visible next", r_data, 64'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_reserved;
        t_mode;
        t_fault;
        t_base;
        t_prio;
        t_xmask;
        t_both;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule